// File: doc/BRIEF.md
# Pipelined Synchronous SRAM Core

A single-port, clock-synchronous memory with registered address, control and write data. Every rising edge of `clk_i` captures the address, the three chip selects, the write controls and the write word. In the following cycle the captured cycle either updates the array, or reads the array into an output register. A write can update any set of 9-bit lanes. Each lane can be enabled by its own strobe under a common byte-write enable. A separate all-lanes write updates the whole word whatever the strobes say.

The shared data bus of the device is split into `wdata_i` and `rdata_o`. A valid flag, `rvalid_o`, takes the place of the tristate output. The output enable only gates the driven state of the output register and is not registered. A cycle that is not selected stops the output one cycle after it is captured. That same cycle raises an idle indication for low-power standby.

Top module: `sram_pipe_top`

## Requirements
- R1: A read is captured at one rising edge. Its word is on `rdata_o` with `rvalid_o` high after the next rising edge, and not before it.
- R2: Lane i is bits [9i+8:9i]. When `all_wr_ni` is high, a selected cycle writes lane i only if `lane_wr_en_ni` is low and `lane_strb_ni[i]` is low. Other lanes keep their contents.
- R3: A selected cycle with `all_wr_ni` low writes all lanes, whatever `lane_wr_en_ni` and `lane_strb_ni` are.
- R4: With `lane_wr_en_ni` high and `all_wr_ni` high, the lane strobes have no effect. The cycle is a read.
- R5: A cycle is selected only when `cs0_ni`=0, `cs1_i`=1 and `cs2_ni`=0. An unselected cycle writes nothing.
- R6: After the edge that commits a write, `rvalid_o` is low.
- R7: An unselected cycle captured at one edge drives `rvalid_o` low after the next edge. A read captured just before it still shows for one cycle.
- R8: `idle_o` is high after an edge that captures an unselected cycle. It is low after an edge that captures a selected cycle.
- R9: `rvalid_o` is high only while the output register holds read data and `oe_ni` is low. The response to `oe_ni` needs no clock edge. `rdata_o` is zero whenever `rvalid_o` is low.
- R10: During reset, `rvalid_o` is 0 and `idle_o` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| addr_i | input | ADDR_W | Word address |
| cs0_ni | input | 1 | Chip select, active low |
| cs1_i | input | 1 | Chip select, active high |
| cs2_ni | input | 1 | Chip select, active low |
| lane_wr_en_ni | input | 1 | Byte-write enable, active low |
| lane_strb_ni | input | LANES | Per-lane write strobes, active low |
| all_wr_ni | input | 1 | All-lanes write, active low |
| oe_ni | input | 1 | Output enable, active low, not registered |
| wdata_i | input | LANES*LANE_W | Write word |
| rdata_o | output | LANES*LANE_W | Read word, zero when not valid |
| rvalid_o | output | 1 | Output is driven |
| idle_o | output | 1 | Captured cycle is unselected |

## Verification
A cycle whose inputs are driven at a falling edge is captured at the next rising edge. Its read result is due on the outputs after the rising edge after that. The bench therefore drives at one falling edge and samples two falling edges later. In between, it drives an unselected filler cycle, which also checks that the result survives exactly one cycle of deselect. `idle_o` is due one rising edge after the cycle it describes, so it is sampled at the first falling edge. Output-enable effects are sampled one time unit after `oe_ni` changes, with no clock edge in between.

// File: rtl/sram_pkg.sv
package sram_pkg;
  typedef enum logic [1:0] {
    CYC_IDLE  = 2'd0,
    CYC_READ  = 2'd1,
    CYC_WRITE = 2'd2
  } cyc_kind_e;
endpackage

// File: rtl/sram_in_stage.sv
module sram_in_stage #(
  parameter int ADDR_W = 6,
  parameter int LANES  = 4,
  parameter int LANE_W = 9,
  localparam int DW    = LANES * LANE_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              cs0_ni,
  input  logic              cs1_i,
  input  logic              cs2_ni,
  input  logic              lane_wr_en_ni,
  input  logic [LANES-1:0]  lane_strb_ni,
  input  logic              all_wr_ni,
  input  logic [DW-1:0]     wdata_i,
  output logic [ADDR_W-1:0] addr_q_o,
  output logic              cs0_q_no,
  output logic              cs1_q_o,
  output logic              cs2_q_no,
  output logic              lane_wr_en_q_no,
  output logic [LANES-1:0]  lane_strb_q_no,
  output logic              all_wr_q_no,
  output logic [DW-1:0]     wdata_q_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      addr_q_o        <= '0;
      cs0_q_no        <= 1'b1;
      cs1_q_o         <= 1'b0;
      cs2_q_no        <= 1'b1;
      lane_wr_en_q_no <= 1'b1;
      lane_strb_q_no  <= '1;
      all_wr_q_no     <= 1'b1;
      wdata_q_o       <= '0;
    end else begin
      addr_q_o        <= addr_i;
      cs0_q_no        <= cs0_ni;
      cs1_q_o         <= cs1_i;
      cs2_q_no        <= cs2_ni;
      lane_wr_en_q_no <= lane_wr_en_ni;
      lane_strb_q_no  <= lane_strb_ni;
      all_wr_q_no     <= all_wr_ni;
      wdata_q_o       <= wdata_i;
    end
  end
endmodule

// File: rtl/sram_wr_decode.sv
module sram_wr_decode
  import sram_pkg::*;
#(
  parameter int LANES = 4
) (
  input  logic             cs0_q_ni,
  input  logic             cs1_q_i,
  input  logic             cs2_q_ni,
  input  logic             lane_wr_en_q_ni,
  input  logic [LANES-1:0] lane_strb_q_ni,
  input  logic             all_wr_q_ni,
  output logic [LANES-1:0] lane_we_o,
  output cyc_kind_e        kind_o
);
  logic sel;
  assign sel = !cs0_q_ni && cs1_q_i && !cs2_q_ni;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    // all-lanes write overrides the enable-qualified strobes
    assign lane_we_o[g] = sel && (!all_wr_q_ni || (!lane_wr_en_q_ni && !lane_strb_q_ni[g]));
  end

  always_comb begin
    if (!sel)            kind_o = CYC_IDLE;
    else if (|lane_we_o) kind_o = CYC_WRITE;
    else                 kind_o = CYC_READ;
  end
endmodule

// File: rtl/sram_lane_array.sv
module sram_lane_array #(
  parameter int ADDR_W = 6,
  parameter int LANES  = 4,
  parameter int LANE_W = 9,
  localparam int DW    = LANES * LANE_W,
  localparam int DEPTH = 1 << ADDR_W
) (
  input  logic              clk_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [LANES-1:0]  lane_we_i,
  input  logic [DW-1:0]     wdata_i,
  output logic [DW-1:0]     rword_o
);
  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic [LANE_W-1:0] mem [DEPTH];

    always_ff @(posedge clk_i) begin
      if (lane_we_i[g]) mem[addr_i] <= wdata_i[g*LANE_W +: LANE_W];
    end

    assign rword_o[g*LANE_W +: LANE_W] = mem[addr_i];
  end
endmodule

// File: rtl/sram_out_stage.sv
module sram_out_stage
  import sram_pkg::*;
#(
  parameter int LANES  = 4,
  parameter int LANE_W = 9,
  localparam int DW    = LANES * LANE_W
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  cyc_kind_e     kind_i,
  input  logic [DW-1:0] rword_i,
  input  logic          oe_ni,
  output logic [DW-1:0] rdata_o,
  output logic          rvalid_o
);
  logic          live_q;
  logic [DW-1:0] dout_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      live_q <= 1'b0;
      dout_q <= '0;
    end else begin
      live_q <= (kind_i == CYC_READ);
      if (kind_i == CYC_READ) dout_q <= rword_i;
    end
  end

  assign rvalid_o = live_q && !oe_ni;
  assign rdata_o  = rvalid_o ? dout_q : '0;

  assert_read_lat_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (kind_i == CYC_READ) |=> live_q);
  assert_wr_quiet_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (kind_i == CYC_WRITE) |=> !rvalid_o);
  assert_desel_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (kind_i == CYC_IDLE) |=> !rvalid_o);
endmodule

// File: rtl/sram_pipe_top.sv
module sram_pipe_top
  import sram_pkg::*;
#(
  parameter int ADDR_W = 6,
  parameter int LANES  = 4,
  parameter int LANE_W = 9,
  localparam int DW    = LANES * LANE_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              cs0_ni,
  input  logic              cs1_i,
  input  logic              cs2_ni,
  input  logic              lane_wr_en_ni,
  input  logic [LANES-1:0]  lane_strb_ni,
  input  logic              all_wr_ni,
  input  logic              oe_ni,
  input  logic [DW-1:0]     wdata_i,
  output logic [DW-1:0]     rdata_o,
  output logic              rvalid_o,
  output logic              idle_o
);
  logic [ADDR_W-1:0] addr_q;
  logic              cs0_qn, cs1_q, cs2_qn, lane_wr_en_qn, all_wr_qn;
  logic [LANES-1:0]  lane_strb_qn, lane_we;
  logic [DW-1:0]     wdata_q, rword;
  cyc_kind_e         kind;

  sram_in_stage #(.ADDR_W(ADDR_W), .LANES(LANES), .LANE_W(LANE_W)) u_in (
    .clk_i, .rst_ni, .addr_i, .cs0_ni, .cs1_i, .cs2_ni,
    .lane_wr_en_ni, .lane_strb_ni, .all_wr_ni, .wdata_i,
    .addr_q_o(addr_q), .cs0_q_no(cs0_qn), .cs1_q_o(cs1_q), .cs2_q_no(cs2_qn),
    .lane_wr_en_q_no(lane_wr_en_qn), .lane_strb_q_no(lane_strb_qn),
    .all_wr_q_no(all_wr_qn), .wdata_q_o(wdata_q)
  );

  sram_wr_decode #(.LANES(LANES)) u_dec (
    .cs0_q_ni(cs0_qn), .cs1_q_i(cs1_q), .cs2_q_ni(cs2_qn),
    .lane_wr_en_q_ni(lane_wr_en_qn), .lane_strb_q_ni(lane_strb_qn),
    .all_wr_q_ni(all_wr_qn), .lane_we_o(lane_we), .kind_o(kind)
  );

  sram_lane_array #(.ADDR_W(ADDR_W), .LANES(LANES), .LANE_W(LANE_W)) u_arr (
    .clk_i, .addr_i(addr_q), .lane_we_i(lane_we), .wdata_i(wdata_q), .rword_o(rword)
  );

  sram_out_stage #(.LANES(LANES), .LANE_W(LANE_W)) u_out (
    .clk_i, .rst_ni, .kind_i(kind), .rword_i(rword), .oe_ni, .rdata_o, .rvalid_o
  );

  assign idle_o = (kind == CYC_IDLE);

  assert_all_lanes_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!cs0_qn && cs1_q && !cs2_qn && !all_wr_qn) |-> (&lane_we));
  assert_sel_gate_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|lane_we) |-> (!cs0_qn && cs1_q && !cs2_qn));
  assert_strobe_gate_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (all_wr_qn && lane_wr_en_qn) |-> (lane_we == '0));
endmodule

// File: tb/sim_sram_pipe_top.sv
module sim_sram_pipe_top;
  localparam int AW = 6, LN = 4, LW = 9, DW = LN * LW;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [AW-1:0] addr;
  logic cs0_n, cs1, cs2_n, bwe_n, gw_n, oe_n;
  logic [LN-1:0] strb_n;
  logic [DW-1:0] wdata, rdata;
  logic rvalid, idle;
  int checks = 0, errors = 0;

  always #5 clk = ~clk;

  sram_pipe_top #(.ADDR_W(AW), .LANES(LN), .LANE_W(LW)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .addr_i(addr), .cs0_ni(cs0_n), .cs1_i(cs1),
    .cs2_ni(cs2_n), .lane_wr_en_ni(bwe_n), .lane_strb_ni(strb_n), .all_wr_ni(gw_n),
    .oe_ni(oe_n), .wdata_i(wdata), .rdata_o(rdata), .rvalid_o(rvalid), .idle_o(idle)
  );

  typedef struct packed {
    logic [2:0]    cs;     // {cs0_n, cs1, cs2_n}
    logic          bwe_n;
    logic [LN-1:0] strb_n;
    logic          gw_n;
    logic [AW-1:0] addr;
    logic [DW-1:0] wd;
    logic          ev;
    logic [DW-1:0] ed;
    logic [3:0]    req;
  } vec_t;

  localparam logic [DW-1:0] WA = {9'h101, 9'h102, 9'h103, 9'h104};
  localparam logic [DW-1:0] WB = {9'h1F1, 9'h1F2, 9'h1F3, 9'h1F4};
  localparam logic [2:0] SEL = 3'b010;
  localparam int NV = 13;

  localparam vec_t VECS [NV] = '{
    '{SEL, 1'b1, 4'hF, 1'b0, 6'd3, WA, 1'b0, '0, 4'd6},                       // R6 write
    '{SEL, 1'b1, 4'hF, 1'b1, 6'd3, '0, 1'b1, WA, 4'd3},                       // R3 read back
    '{SEL, 1'b0, 4'hE, 1'b1, 6'd3, WB, 1'b0, '0, 4'd2},                       // R2 lane 0 only
    '{SEL, 1'b1, 4'hF, 1'b1, 6'd3, '0, 1'b1, {9'h101,9'h102,9'h103,9'h1F4}, 4'd2},
    '{SEL, 1'b1, 4'h0, 1'b1, 6'd3, WB, 1'b1, {9'h101,9'h102,9'h103,9'h1F4}, 4'd4}, // R4 strobes w/o enable = read
    '{SEL, 1'b1, 4'hF, 1'b0, 6'd7, WB, 1'b0, '0, 4'd3},                       // R3 gw, bwe off
    '{SEL, 1'b1, 4'hF, 1'b1, 6'd7, '0, 1'b1, WB, 4'd3},
    '{SEL, 1'b0, 4'hD, 1'b0, 6'd7, WA, 1'b0, '0, 4'd3},                       // R3 gw over partial strobes
    '{SEL, 1'b1, 4'hF, 1'b1, 6'd7, '0, 1'b1, WA, 4'd3},
    '{SEL, 1'b0, 4'h3, 1'b1, 6'd3, WB, 1'b0, '0, 4'd2},                       // R2 lanes 3,2
    '{3'b110, 1'b1, 4'hF, 1'b0, 6'd3, WA, 1'b0, '0, 4'd5},                    // R5 cs0 high, write ignored
    '{3'b000, 1'b1, 4'hF, 1'b0, 6'd3, WA, 1'b0, '0, 4'd5},                    // R5 cs1 low
    '{SEL, 1'b1, 4'hF, 1'b1, 6'd3, '0, 1'b1, {9'h1F1,9'h1F2,9'h103,9'h1F4}, 4'd5}  // R2 R5 contents
  };

  task automatic chk(input logic ok, input string req, input logic [DW-1:0] act,
                     input logic [DW-1:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic drive(input logic [2:0] cs, input logic bwe, input logic [LN-1:0] sn,
                       input logic gw, input logic [AW-1:0] a, input logic [DW-1:0] d);
    {cs0_n, cs1, cs2_n} = cs;
    bwe_n = bwe; strb_n = sn; gw_n = gw; addr = a; wdata = d;
  endtask

  task automatic nop();
    drive(3'b110, 1'b1, 4'hF, 1'b1, '0, '0);
  endtask

  initial begin
    #2_000_000;
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    oe_n = 1'b0;
    nop();
    repeat (3) @(negedge clk);
    // R10 reset state
    chk(rvalid == 1'b0, "R10 rvalid", DW'(rvalid), '0);
    chk(idle == 1'b1, "R10 idle", DW'(idle), DW'(1));
    rst_n = 1'b1;
    @(negedge clk);

    for (int i = 0; i < NV; i++) begin
      drive(VECS[i].cs, VECS[i].bwe_n, VECS[i].strb_n, VECS[i].gw_n, VECS[i].addr, VECS[i].wd);
      @(negedge clk);
      nop();
      @(negedge clk);
      chk(rvalid == VECS[i].ev, $sformatf("R%0d vec %0d valid", VECS[i].req, i),
          DW'(rvalid), DW'(VECS[i].ev));
      chk(rdata == VECS[i].ed, $sformatf("R%0d vec %0d data", VECS[i].req, i),
          rdata, VECS[i].ed);
    end

    // R1 latency: not present after the capturing edge, present after the next
    drive(SEL, 1'b1, 4'hF, 1'b1, 6'd7, '0);
    @(negedge clk);
    chk(rvalid == 1'b0, "R1 early", DW'(rvalid), '0);
    chk(idle == 1'b0, "R8 selected", DW'(idle), '0);
    nop();
    @(negedge clk);
    chk(rvalid == 1'b1 && rdata == WA, "R1 data", rdata, WA);
    chk(idle == 1'b1, "R8 deselected", DW'(idle), DW'(1));
    // R7 deselect drops output one cycle later
    @(negedge clk);
    chk(rvalid == 1'b0, "R7 off", DW'(rvalid), '0);

    // back-to-back reads R1
    drive(SEL, 1'b1, 4'hF, 1'b1, 6'd3, '0);
    @(negedge clk);
    drive(SEL, 1'b1, 4'hF, 1'b1, 6'd7, '0);
    @(negedge clk);
    chk(rdata == {9'h1F1,9'h1F2,9'h103,9'h1F4}, "R1 b2b first", rdata,
        {9'h1F1,9'h1F2,9'h103,9'h1F4});
    nop();
    @(negedge clk);
    chk(rdata == WA, "R1 b2b second", rdata, WA);

    // R9 output enable acts without a clock edge
    oe_n = 1'b1;
    #1;
    chk(rvalid == 1'b0 && rdata == '0, "R9 oe off", rdata, '0);
    oe_n = 1'b0;
    #1;
    chk(rvalid == 1'b1 && rdata == WA, "R9 oe on", rdata, WA);
    @(negedge clk);
    chk(rvalid == 1'b0, "R7 after nop", DW'(rvalid), '0);

    // R6 read then write: write cycle clears output
    drive(SEL, 1'b1, 4'hF, 1'b1, 6'd7, '0);
    @(negedge clk);
    drive(SEL, 1'b1, 4'hF, 1'b0, 6'd9, WB);
    @(negedge clk);
    chk(rvalid == 1'b1 && rdata == WA, "R1 before write", rdata, WA);
    nop();
    @(negedge clk);
    chk(rvalid == 1'b0, "R6 write quiet", DW'(rvalid), '0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule